// File: doc/BRIEF.md
# Clock generator control register bank

This block holds the settings of a line-locked pixel clock generator and drives the divide-by-N line counter that closes its feedback loop. Software reaches it through a byte-wide address/data port: a write strobe with an address and a data byte, and a read data bus that combinationally reflects the register at the current address. The serial host front end and the analog loop sit outside the block.

The 12-bit feedback divide ratio is too wide for one byte, so it is split. The upper eight bits go to one address, where a write only stages them. The low four bits go to a second address, and a write there commits the staged byte and the new nibble together in one cycle. A separate control byte selects the oscillator range and the charge pump current code, and chooses between the internally locked clock and an external clock. When the external clock is chosen, the ratio no longer matters and the line counter rests at zero. A read-only revision byte identifies the silicon.

The line counter counts pixel clock cycles (the block clock) from zero up to the ratio minus one and then wraps. A ratio below 2 is raised to 2. A newly committed ratio is picked up only at the next wrap, so the line in progress always finishes at its old length.

Top module: `clkgen_regbank`

## Requirements
- R1: After reset, reads return the REV parameter (default 0x12) at address 0x00, 0x69 at 0x01, 0xD0 at 0x02 and 0x48 at 0x03, and `div_ratio` is 1693.
- R2: A write to address 0x00 changes nothing: the revision still reads back, and all other registers and outputs keep their values.
- R3: A write to address 0x01 stores its byte as the staged upper ratio. The byte reads back at 0x01 on the next cycle, and `div_ratio` does not change.
- R4: A write to address 0x02 sets `div_ratio` to {staged upper byte, wdata[7:4]} on the next cycle. Address 0x02 reads back as {active low nibble, 4'b0000}.
- R5: Address 0x03 holds the oscillator range in bits 7:6 (`osc_range`), the charge pump code in bits 5:3 (`pump_code`) and the clock source in bit 2 (`ext_clk_sel`, 1 = external). Bits 1:0 read as 0.
- R6: A read of any address above 0x03 returns 0x00.
- R7: With the internal clock selected and a steady ratio N, `line_wrap` pulses once every max(N,2) cycles. At each pulse `line_count` equals max(N,2)-1, and on the following cycle it is 0.
- R8: A ratio committed in the middle of a line leaves that line at its old length. The new length applies from the next line on.
- R9: While `ext_clk_sel` is 1, `line_count` stays 0 and `line_wrap` stays low, and ratio writes still update `div_ratio`. After the bit is cleared, lines run at max(ratio,2) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle while high |
| addr | input | 8 | Register address for both reads and writes |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data for `addr`, combinational |
| div_ratio | output | 12 | Active (committed) divide ratio |
| osc_range | output | 2 | Oscillator range select |
| pump_code | output | 3 | Charge pump current code |
| ext_clk_sel | output | 1 | Clock source select, 1 = external |
| line_count | output | 12 | Current position within the line |
| line_wrap | output | 1 | High on the last cycle of each line |

## Verification
Register effects are due one cycle after the write strobe. The bench drives each write on a falling edge, removes it at the next falling edge, and reads `rdata` and the field outputs only after that, so one rising edge lies between the stimulus and the sample. `rdata` has no latency, so each read settles one time unit after `addr` changes. Line-length effects are due at wrap boundaries rather than at fixed cycle counts. A falling-edge monitor timestamps every `line_wrap` pulse, and after each commit the bench lets one whole line pass before it compares a measured gap, which confines the old-length line to the gap that R8 checks.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int LO_W    = 4;
  localparam int RATIO_W = DATA_W + LO_W;
  localparam int MIN_RATIO = 2;

  localparam logic [ADDR_W-1:0] A_REV  = 8'h00;
  localparam logic [ADDR_W-1:0] A_DIVH = 8'h01;
  localparam logic [ADDR_W-1:0] A_DIVL = 8'h02;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h03;

  // Control byte bit positions
  localparam int OSC_HI  = 7;
  localparam int OSC_LO  = 6;
  localparam int PUMP_HI = 5;
  localparam int PUMP_LO = 3;
  localparam int EXT_BIT = 2;

  function automatic logic [RATIO_W-1:0] clamp_ratio(input logic [RATIO_W-1:0] v);
    if (v < RATIO_W'(MIN_RATIO)) return RATIO_W'(MIN_RATIO);
    return v;
  endfunction
endpackage

// File: rtl/clkgen_regfile.sv
module clkgen_regfile
  import clkgen_pkg::*;
#(
  parameter logic [DATA_W-1:0]  REV       = 8'h12,
  parameter logic [RATIO_W-1:0] RATIO_RST = 12'd1693,
  parameter logic [1:0]         OSC_RST   = 2'b01,
  parameter logic [2:0]         PUMP_RST  = 3'b001
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [RATIO_W-1:0]  active_ratio,
  output logic [1:0]          osc_range,
  output logic [2:0]          pump_code,
  output logic                ext_sel
);
  localparam int HI_W = RATIO_W - LO_W;

  logic [HI_W-1:0] stage_hi;
  logic [HI_W-1:0] act_hi;
  logic [LO_W-1:0] act_lo;

  logic wr_hi, wr_lo, wr_ctrl;
  assign wr_hi   = wr_en && (addr == A_DIVH);
  assign wr_lo   = wr_en && (addr == A_DIVL);
  assign wr_ctrl = wr_en && (addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_hi <= RATIO_RST[RATIO_W-1:LO_W];
      act_hi   <= RATIO_RST[RATIO_W-1:LO_W];
      act_lo   <= RATIO_RST[LO_W-1:0];
    end else begin
      if (wr_hi) stage_hi <= wdata;
      if (wr_lo) begin
        act_hi <= stage_hi;
        act_lo <= wdata[DATA_W-1 -: LO_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_range <= OSC_RST;
      pump_code <= PUMP_RST;
      ext_sel   <= 1'b0;
    end else if (wr_ctrl) begin
      osc_range <= wdata[OSC_HI:OSC_LO];
      pump_code <= wdata[PUMP_HI:PUMP_LO];
      ext_sel   <= wdata[EXT_BIT];
    end
  end

  assign active_ratio = {act_hi, act_lo};

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_REV:  rdata = REV;
      A_DIVH: rdata = stage_hi;
      A_DIVL: rdata = {act_lo, {(DATA_W-LO_W){1'b0}}};
      A_CTRL: begin
        rdata[OSC_HI:OSC_LO]   = osc_range;
        rdata[PUMP_HI:PUMP_LO] = pump_code;
        rdata[EXT_BIT]         = ext_sel;
      end
      default: rdata = '0;
    endcase
  end

  // R3: staging the upper byte leaves the active ratio alone
  p_stage_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIVH) |=> $stable(active_ratio));

  // R4: a commit copies the staged byte into the active upper bits
  p_commit_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIVL) |=> (active_ratio[RATIO_W-1:LO_W] == stage_hi));

  // R2: writes to the revision address disturb no stored state
  p_rev_write_inert_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_REV) |=> ($stable(active_ratio) && $stable(stage_hi) && $stable(ext_sel)));
endmodule

// File: rtl/clkgen_line_counter.sv
module clkgen_line_counter
  import clkgen_pkg::*;
#(
  parameter logic [RATIO_W-1:0] RATIO_RST = 12'd1693
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic               ext_sel,
  output logic [RATIO_W-1:0] line_count,
  output logic               line_wrap
);
  logic [RATIO_W-1:0] cur_len;
  logic [RATIO_W-1:0] count;
  logic               line_end;

  assign line_end = (count == cur_len - RATIO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      cur_len <= clamp_ratio(RATIO_RST);
    end else if (ext_sel) begin
      count   <= '0;
      cur_len <= clamp_ratio(ratio_in);
    end else if (line_end) begin
      count   <= '0;
      cur_len <= clamp_ratio(ratio_in);
    end else begin
      count   <= count + RATIO_W'(1);
    end
  end

  assign line_count = count;
  assign line_wrap  = line_end && !ext_sel;

  // R7: the loaded line length never drops below the minimum
  p_min_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cur_len >= RATIO_W'(MIN_RATIO));

  // R7: the count restarts at zero after a wrap
  p_wrap_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_wrap |=> (line_count == '0));

  // R8: the line length is held for the whole line
  p_len_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_end && !ext_sel) |=> $stable(cur_len));

  // R9: the counter rests while the external clock is selected
  p_ext_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && $past(ext_sel)) |-> (line_count == '0 && !line_wrap));
endmodule

// File: rtl/clkgen_regbank.sv
module clkgen_regbank
  import clkgen_pkg::*;
#(
  parameter logic [DATA_W-1:0]  REV       = 8'h12,
  parameter logic [RATIO_W-1:0] RATIO_RST = 12'd1693,
  parameter logic [1:0]         OSC_RST   = 2'b01,
  parameter logic [2:0]         PUMP_RST  = 3'b001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [RATIO_W-1:0] div_ratio,
  output logic [1:0]         osc_range,
  output logic [2:0]         pump_code,
  output logic               ext_clk_sel,
  output logic [RATIO_W-1:0] line_count,
  output logic               line_wrap
);
  clkgen_regfile #(
    .REV(REV), .RATIO_RST(RATIO_RST), .OSC_RST(OSC_RST), .PUMP_RST(PUMP_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .active_ratio(div_ratio), .osc_range(osc_range),
    .pump_code(pump_code), .ext_sel(ext_clk_sel)
  );

  clkgen_line_counter #(.RATIO_RST(RATIO_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ratio_in(div_ratio), .ext_sel(ext_clk_sel),
    .line_count(line_count), .line_wrap(line_wrap)
  );
endmodule

// File: tb/clkgen_regbank_test.sv
module clkgen_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] REV_V = 8'h12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [11:0] div_ratio;
  logic [1:0]  osc_range;
  logic [2:0]  pump_code;
  logic        ext_clk_sel;
  logic [11:0] line_count;
  logic        line_wrap;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_wrap_cyc = 0;
  int last_gap = 0;
  int wrap_cnt = 0;
  int wrap_val = 0;

  clkgen_regbank #(.REV(REV_V)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .div_ratio(div_ratio), .osc_range(osc_range),
    .pump_code(pump_code), .ext_clk_sel(ext_clk_sel),
    .line_count(line_count), .line_wrap(line_wrap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (line_wrap) begin
        last_gap = cyc - last_wrap_cyc;
        last_wrap_cyc = cyc;
        wrap_val = int'(line_count);
        wrap_cnt = wrap_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_wraps(input int n);
    int start;
    start = wrap_cnt;
    wait (wrap_cnt >= start + n);
  endtask

  function automatic int clampv(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  task automatic commit(input int r);
    do_write(8'h01, 8'(r >> 4));
    do_write(8'h02, {4'(r), 4'h9});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    do_read(8'h00, rd); check(rd == REV_V, "R1 rev", rd, REV_V);
    do_read(8'h01, rd); check(rd == 8'h69, "R1 div hi", rd, 8'h69);
    do_read(8'h02, rd); check(rd == 8'hD0, "R1 div lo", rd, 8'hD0);
    do_read(8'h03, rd); check(rd == 8'h48, "R1 ctrl", rd, 8'h48);
    check(div_ratio == 12'd1693, "R1 div_ratio", div_ratio, 1693);

    // R2: revision address ignores writes
    do_write(8'h00, 8'hFF);
    do_read(8'h00, rd); check(rd == REV_V, "R2 rev kept", rd, REV_V);
    do_read(8'h03, rd); check(rd == 8'h48, "R2 ctrl kept", rd, 8'h48);
    do_read(8'h01, rd); check(rd == 8'h69, "R2 stage kept", rd, 8'h69);
    check(div_ratio == 12'd1693, "R2 div_ratio kept", div_ratio, 1693);

    // R3: staging sweep, active ratio untouched
    for (int v = 0; v < 256; v++) begin
      do_write(8'h01, 8'(v));
      do_read(8'h01, rd); check(rd == 8'(v), "R3 staged readback", rd, v);
      check(div_ratio == 12'd1693, "R3 div_ratio unchanged", div_ratio, 1693);
    end

    // R4: commit sweep over all low nibbles with varied upper bytes
    for (int n = 0; n < 16; n++) begin
      hi = 8'(n * 17 + 3);
      do_write(8'h01, hi);
      do_write(8'h02, {4'(n), 4'(15 - n)});
      check(div_ratio == {hi, 4'(n)}, "R4 commit", div_ratio, int'({hi, 4'(n)}));
      do_read(8'h02, rd); check(rd == {4'(n), 4'h0}, "R4 lo readback", rd, n << 4);
    end

    // R5: control byte sweep (ext bit forced 0 at the end)
    for (int v = 0; v < 256; v++) begin
      do_write(8'h03, 8'(v));
      do_read(8'h03, rd); check(rd == (8'(v) & 8'hFC), "R5 ctrl readback", rd, v & 8'hFC);
      check(osc_range == 2'(v >> 6), "R5 osc_range", osc_range, (v >> 6) & 3);
      check(pump_code == 3'(v >> 3), "R5 pump_code", pump_code, (v >> 3) & 7);
      check(ext_clk_sel == v[2], "R5 ext_clk_sel", ext_clk_sel, (v >> 2) & 1);
    end
    do_write(8'h03, 8'h48);

    // R6: unmapped addresses read zero
    for (int a = 4; a < 256; a++) begin
      do_read(8'(a), rd); check(rd == 8'h00, "R6 unmapped", rd, 0);
    end

    // R7: line period sweep including clamped ratios and the maximum
    for (int r = 0; r < 26; r++) begin
      commit(r);
      wait_wraps(2);
      check(last_gap == clampv(r), "R7 period", last_gap, clampv(r));
      check(wrap_val == clampv(r) - 1, "R7 count at wrap", wrap_val, clampv(r) - 1);
      @(negedge clk);
      check(line_count == 12'd0, "R7 restart", line_count, 0);
    end
    commit(4095);
    wait_wraps(2);
    check(last_gap == 4095, "R7 period max", last_gap, 4095);

    // R8: mid-line commit keeps the current line length
    commit(10);
    wait_wraps(2);
    check(last_gap == 10, "R8 setup", last_gap, 10);
    commit(5);
    wait_wraps(1);
    check(last_gap == 10, "R8 current line kept", last_gap, 10);
    wait_wraps(1);
    check(last_gap == 5, "R8 new line length", last_gap, 5);
    commit(3);
    wait_wraps(1);
    check(last_gap == 5, "R8 second change kept", last_gap, 5);
    wait_wraps(1);
    check(last_gap == 3, "R8 second change applied", last_gap, 3);

    // R9: external clock holds the counter idle
    do_write(8'h03, 8'h4C);
    begin
      int w0;
      repeat (2) @(negedge clk);
      w0 = wrap_cnt;
      commit(7);
      check(div_ratio == 12'd7, "R9 div_ratio while ext", div_ratio, 7);
      repeat (30) @(negedge clk);
      check(wrap_cnt == w0, "R9 no wraps", wrap_cnt, w0);
      check(line_count == 12'd0, "R9 count idle", line_count, 0);
    end
    do_write(8'h03, 8'h48);
    wait_wraps(2);
    check(last_gap == 7, "R9 resume period", last_gap, 7);

    finish_run();
  end
endmodule